// File: doc/BRIEF.md
# Radio Link-Layer Timebase Timer

This block keeps a 40-bit time reference for scheduling a radio link layer. The low 16 bits form a sub-period counter that climbs once per clock and restarts from zero at a programmable period. The upper 24 bits count completed periods. Four compare units watch the two halves. Two of them match on the sub-period count, and two match on the period count. Each compare can be steered to one of three single-cycle strobes: receive start, transmit start, or interrupt.

Two frame events take a 40-bit snapshot of the time: a start-of-frame delimiter, either received or sent, and the end of a transmission. Software reaches the block through a byte-wide register port. A read of the live time is kept consistent because reading its low byte freezes the upper four bytes in a shadow. A status byte reports whether a snapshot is unread, which event produced it, and whether a snapshot was overwritten before it was read.

Top module: `lltb_timebase`

## Requirements
- R1: The sub-period counter resets to 0 and adds 1 each clock. In a cycle where it is greater than or equal to the period register, it returns to 0 instead. The period register resets to 16'hFFFF and is written little-endian at byte addresses 0 (low) and 1 (high).
- R2: The period counter resets to 0 and adds 1, modulo 2^24, in exactly the cycles in which the sub-period counter returns to 0.
- R3: After reset, every readable register reads as follows: the period bytes read 8'hFF; the compare bytes, the route byte (address 23) and the status byte (address 12) read 0. No strobe is raised.
- R4: When a start-of-frame or end-of-transmission pulse is high at a clock edge, the snapshot register takes {period count, sub-period count} as it stood before that edge. The snapshot reads low byte first at addresses 7 to 11.
- R5: A read at address 2 returns the live sub-period low byte. In the same edge it latches the upper 32 bits of the time into a shadow, which reads at addresses 3 to 6 (sub-period high byte, then period count bytes from low to high). The shadow holds until the next read at address 2.
- R6: Sub-period compare A (addresses 13 low, 14 high) and compare B (15, 16) each raise their routed strobe combinationally in every cycle in which the sub-period counter equals their value. With a period above the value, this gives one cycle per period.
- R7: Period-count compare A (addresses 17 to 19, low byte first) and B (20 to 22) raise their routed strobe in the single cycle where the period count equals their value and the sub-period counter is 0.
- R8: The route byte holds 2-bit fields: bits 1:0 for sub compare A, bits 3:2 for sub compare B, bits 5:4 for period compare A and bits 7:6 for period compare B. The field codes are 0 = off, 1 = rx_start, 2 = tx_start and 3 = irq_out. A field set to off raises nothing. Sources routed to the same strobe are ORed.
- R9: Status bit 0 (pending) is set by a snapshot and cleared by a read of address 7. Status bit 2 records the source: 0 for start-of-frame, 1 for end-of-transmission. When both pulses come in the same cycle, the start-of-frame source is recorded.
- R10: Status bit 1 (overrun) is set when a snapshot arrives while pending is set and address 7 is not read in that cycle. The newer snapshot replaces the older one. Writing a 1 to bit 1 of address 12 clears overrun without clearing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (for read side effects) |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sof_evt | input | 1 | Start-of-frame delimiter seen or sent |
| eot_evt | input | 1 | Transmission ended |
| rx_start | output | 1 | Receive start strobe |
| tx_start | output | 1 | Transmit start strobe |
| irq_out | output | 1 | Interrupt strobe |

## Verification
Counting is checked with two snapshots taken a known number of cycles apart, after the period has been shortened below the running count. The difference, expressed as period count times period plus sub count, must equal the elapsed cycles, which separates a correct wrap from one that is early, late, or missing its carry. A strobe is caught in the same cycle it appears by taking a snapshot at once. The snapshot must show the compare value, with the sub count at 0 for the period compares. Pulse counts over fixed windows tell apart each route code, the off setting and several sources sharing one strobe. The atomic read is proven by a snapshot taken in the edge where the low byte is read, and the shadow must match it after the counter has moved on. The event patterns used are each event alone, both together, and a second event with no read in between. These separate source priority from overrun.

// File: rtl/lltb_pkg.sv
package lltb_pkg;
    localparam int SUB_W  = 16;
    localparam int PER_W  = 24;
    localparam int TIME_W = SUB_W + PER_W;
    localparam int N_CMP  = 2;

    typedef enum logic [1:0] {
        ROUTE_OFF = 2'd0,
        ROUTE_RX  = 2'd1,
        ROUTE_TX  = 2'd2,
        ROUTE_IRQ = 2'd3
    } route_e;

    localparam logic [4:0] A_PER_LO = 5'd0;
    localparam logic [4:0] A_PER_HI = 5'd1;
    localparam logic [4:0] A_TIME0  = 5'd2;
    localparam logic [4:0] A_TIME1  = 5'd3;
    localparam logic [4:0] A_TIME2  = 5'd4;
    localparam logic [4:0] A_TIME3  = 5'd5;
    localparam logic [4:0] A_TIME4  = 5'd6;
    localparam logic [4:0] A_CAP0   = 5'd7;
    localparam logic [4:0] A_CAP1   = 5'd8;
    localparam logic [4:0] A_CAP2   = 5'd9;
    localparam logic [4:0] A_CAP3   = 5'd10;
    localparam logic [4:0] A_CAP4   = 5'd11;
    localparam logic [4:0] A_STAT   = 5'd12;
    localparam logic [4:0] A_CSA0   = 5'd13;
    localparam logic [4:0] A_CSA1   = 5'd14;
    localparam logic [4:0] A_CSB0   = 5'd15;
    localparam logic [4:0] A_CSB1   = 5'd16;
    localparam logic [4:0] A_COA0   = 5'd17;
    localparam logic [4:0] A_COA1   = 5'd18;
    localparam logic [4:0] A_COA2   = 5'd19;
    localparam logic [4:0] A_COB0   = 5'd20;
    localparam logic [4:0] A_COB1   = 5'd21;
    localparam logic [4:0] A_COB2   = 5'd22;
    localparam logic [4:0] A_ROUTE  = 5'd23;
endpackage

// File: rtl/lltb_counter.sv
module lltb_counter #(
    parameter int SW = 16,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] period,
    output logic [SW-1:0] sub_q,
    output logic [PW-1:0] per_q
);
    localparam logic [SW-1:0] SUB_ONE = 1;
    localparam logic [PW-1:0] PER_ONE = 1;

    typedef struct packed {
        logic [SW-1:0] sub;
        logic [PW-1:0] per;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.sub >= period) begin
            s_d.sub = '0;
            s_d.per = s_q.per + PER_ONE;
        end else begin
            s_d.sub = s_q.sub + SUB_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sub_q = s_q.sub;
    assign per_q = s_q.per;
endmodule

// File: rtl/lltb_cmp.sv
module lltb_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0]     cnt,
    input  logic [W-1:0]     val,
    input  logic             qual,
    input  lltb_pkg::route_e route,
    output logic [2:0]       hit   // {irq, tx, rx}
);
    always_comb begin
        hit = '0;
        if (qual && (cnt == val)) begin
            case (route)
                lltb_pkg::ROUTE_RX:  hit[0] = 1'b1;
                lltb_pkg::ROUTE_TX:  hit[1] = 1'b1;
                lltb_pkg::ROUTE_IRQ: hit[2] = 1'b1;
                default:             hit    = '0;
            endcase
        end
    end
endmodule

// File: rtl/lltb_capture.sv
module lltb_capture #(
    parameter int TW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          eot,
    input  logic [TW-1:0] now,
    input  logic          ack,
    input  logic          clr_ovr,
    output logic [TW-1:0] cap_q,
    output logic          pend_q,
    output logic          ovr_q,
    output logic          src_q
);
    typedef struct packed {
        logic [TW-1:0] cap;
        logic          pend;
        logic          ovr;
        logic          src;
    } cap_t;

    cap_t c_d, c_q;
    logic take;

    always_comb begin
        take = sof | eot;
        c_d  = c_q;
        if (clr_ovr) c_d.ovr = 1'b0;
        if (take) begin
            c_d.cap  = now;
            c_d.src  = ~sof;          // start-of-frame wins a tie
            c_d.pend = 1'b1;
            if (c_q.pend && !ack) c_d.ovr = 1'b1;
        end else if (ack) begin
            c_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cap_q  = c_q.cap;
    assign pend_q = c_q.pend;
    assign ovr_q  = c_q.ovr;
    assign src_q  = c_q.src;
endmodule

// File: rtl/lltb_timebase.sv
module lltb_timebase
    import lltb_pkg::*;
#(
    parameter logic [15:0] PERIOD_RST = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_re,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sof_evt,
    input  logic       eot_evt,
    output logic       rx_start,
    output logic       tx_start,
    output logic       irq_out
);
    localparam int SHW = TIME_W - 8;

    typedef struct packed {
        logic [SUB_W-1:0]            period;
        logic [N_CMP-1:0][SUB_W-1:0] csub;
        logic [N_CMP-1:0][PER_W-1:0] cper;
        logic [7:0]                  route;
        logic [SHW-1:0]              shadow;
    } regs_t;

    regs_t r_d, r_q;

    logic [SUB_W-1:0]  sub_q;
    logic [PER_W-1:0]  per_q;
    logic [TIME_W-1:0] now;
    logic [TIME_W-1:0] cap_q;
    logic              pend_q, ovr_q, src_q;
    logic              cap_ack, clr_ovr;
    logic [SUB_W-1:0]  period_w;
    logic [2:0]        hits [2*N_CMP];

    assign period_w = r_q.period;
    assign now      = {per_q, sub_q};
    assign cap_ack  = reg_re && (reg_addr == A_CAP0);
    assign clr_ovr  = reg_we && (reg_addr == A_STAT) && reg_wdata[1];

    lltb_counter #(.SW(SUB_W), .PW(PER_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .period(period_w),
        .sub_q(sub_q), .per_q(per_q)
    );

    lltb_capture #(.TW(TIME_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sof(sof_evt), .eot(eot_evt), .now(now),
        .ack(cap_ack), .clr_ovr(clr_ovr), .cap_q(cap_q),
        .pend_q(pend_q), .ovr_q(ovr_q), .src_q(src_q)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_sub
        lltb_cmp #(.W(SUB_W)) u_cs (
            .cnt(sub_q), .val(r_q.csub[g]), .qual(1'b1),
            .route(route_e'(r_q.route[2*g +: 2])), .hit(hits[g])
        );
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_per
        lltb_cmp #(.W(PER_W)) u_cp (
            .cnt(per_q), .val(r_q.cper[g]), .qual(sub_q == '0),
            .route(route_e'(r_q.route[2*N_CMP + 2*g +: 2])), .hit(hits[N_CMP + g])
        );
    end

    always_comb begin
        logic [2:0] any;
        any = '0;
        for (int i = 0; i < 2*N_CMP; i++) any = any | hits[i];
        rx_start = any[0];
        tx_start = any[1];
        irq_out  = any[2];
    end

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                A_PER_LO: r_d.period[7:0]   = reg_wdata;
                A_PER_HI: r_d.period[15:8]  = reg_wdata;
                A_CSA0:   r_d.csub[0][7:0]  = reg_wdata;
                A_CSA1:   r_d.csub[0][15:8] = reg_wdata;
                A_CSB0:   r_d.csub[1][7:0]  = reg_wdata;
                A_CSB1:   r_d.csub[1][15:8] = reg_wdata;
                A_COA0:   r_d.cper[0][7:0]  = reg_wdata;
                A_COA1:   r_d.cper[0][15:8] = reg_wdata;
                A_COA2:   r_d.cper[0][23:16] = reg_wdata;
                A_COB0:   r_d.cper[1][7:0]  = reg_wdata;
                A_COB1:   r_d.cper[1][15:8] = reg_wdata;
                A_COB2:   r_d.cper[1][23:16] = reg_wdata;
                A_ROUTE:  r_d.route         = reg_wdata;
                default:  r_d = r_q;
            endcase
        end
        if (reg_re && (reg_addr == A_TIME0)) r_d.shadow = now[TIME_W-1:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.period <= PERIOD_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_PER_LO: reg_rdata = r_q.period[7:0];
            A_PER_HI: reg_rdata = r_q.period[15:8];
            A_TIME0:  reg_rdata = sub_q[7:0];
            A_TIME1:  reg_rdata = r_q.shadow[7:0];
            A_TIME2:  reg_rdata = r_q.shadow[15:8];
            A_TIME3:  reg_rdata = r_q.shadow[23:16];
            A_TIME4:  reg_rdata = r_q.shadow[31:24];
            A_CAP0:   reg_rdata = cap_q[7:0];
            A_CAP1:   reg_rdata = cap_q[15:8];
            A_CAP2:   reg_rdata = cap_q[23:16];
            A_CAP3:   reg_rdata = cap_q[31:24];
            A_CAP4:   reg_rdata = cap_q[39:32];
            A_STAT:   reg_rdata = {5'b0, src_q, ovr_q, pend_q};
            A_CSA0:   reg_rdata = r_q.csub[0][7:0];
            A_CSA1:   reg_rdata = r_q.csub[0][15:8];
            A_CSB0:   reg_rdata = r_q.csub[1][7:0];
            A_CSB1:   reg_rdata = r_q.csub[1][15:8];
            A_COA0:   reg_rdata = r_q.cper[0][7:0];
            A_COA1:   reg_rdata = r_q.cper[0][15:8];
            A_COA2:   reg_rdata = r_q.cper[0][23:16];
            A_COB0:   reg_rdata = r_q.cper[1][7:0];
            A_COB1:   reg_rdata = r_q.cper[1][15:8];
            A_COB2:   reg_rdata = r_q.cper[1][23:16];
            A_ROUTE:  reg_rdata = r_q.route;
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/lltb_timebase_chk.sv
module lltb_timebase_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] period,
    input logic [15:0] sub,
    input logic [23:0] per,
    input logic        sof,
    input logic        eot,
    input logic        ack,
    input logic        pend,
    input logic        ovr,
    input logic [39:0] cap,
    input logic [7:0]  route,
    input logic        rx,
    input logic        tx,
    input logic        irq
);
    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sub < period) |=> (sub == $past(sub) + 16'd1) && $stable(per)); // R1

    AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sub >= period) |=> (sub == 16'd0) && (per == $past(per) + 24'd1)); // R2

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (sof || eot) |=> (cap == $past({per, sub}))); // R4

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sof || eot) && pend && !ack) |=> ovr); // R10

    AST_ROUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (route == 8'h00) |-> !(rx || tx || irq)); // R8
endmodule

bind lltb_timebase lltb_timebase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .period(period_w), .sub(sub_q), .per(per_q),
    .sof(sof_evt), .eot(eot_evt), .ack(cap_ack), .pend(pend_q), .ovr(ovr_q),
    .cap(cap_q), .route(r_q.route), .rx(rx_start), .tx(tx_start), .irq(irq_out)
);

// File: tb/test_lltb_timebase.sv
module test_lltb_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sof_evt = 1'b0, eot_evt = 1'b0;
    logic       rx_start, tx_start, irq_out;

    int nchk = 0, nfail = 0;
    longint cyc = 0;

    lltb_timebase i_lltb_timebase (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sof_evt(sof_evt), .eot_evt(eot_evt),
        .rx_start(rx_start), .tx_start(tx_start), .irq_out(irq_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_re = 1'b0;
    endtask

    task automatic rd_cap(output logic [39:0] c);
        logic [7:0] b;
        for (int k = 0; k < 5; k++) begin
            rd(5'(7 + k), b);
            c[8*k +: 8] = b;
        end
    endtask

    task automatic pulse(input logic s, input logic e, output longint at);
        @(negedge clk); sof_evt = s; eot_evt = e; at = cyc;
        @(posedge clk); #1 sof_evt = 1'b0; eot_evt = 1'b0;
    endtask

    task automatic count(input int n, output int nrx, output int ntx, output int nirq);
        nrx = 0; ntx = 0; nirq = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nrx += int'(rx_start); ntx += int'(tx_start); nirq += int'(irq_out);
        end
    endtask

    task automatic t_reset();
        logic [7:0] b; int a, t, q;
        rd(5'd0, b);  check("R3 period lo", b, 8'hFF);
        rd(5'd1, b);  check("R3 period hi", b, 8'hFF);
        rd(5'd12, b); check("R3 status", b, 8'h00);
        rd(5'd23, b); check("R3 route", b, 8'h00);
        rd(5'd13, b); check("R3 compare", b, 8'h00);
        count(20, a, t, q);
        check("R3 no strobe", a + t + q, 0);
    endtask

    task automatic t_period();
        logic [39:0] c1, c2; longint p1, p2, v1, v2;
        wr(5'd0, 8'd9); wr(5'd1, 8'd0);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b0, p1); rd_cap(c1);
        repeat (37) @(negedge clk);
        pulse(1'b1, 1'b0, p2); rd_cap(c2);
        check("R1 sub bound 1", longint'(c1[15:0] <= 16'd9), 1);
        check("R1 sub bound 2", longint'(c2[15:0] <= 16'd9), 1);
        v1 = longint'(c1[39:16]) * 10 + longint'(c1[15:0]);
        v2 = longint'(c2[39:16]) * 10 + longint'(c2[15:0]);
        check("R2 elapsed time", v2 - v1, p2 - p1);
    endtask

    task automatic t_subcmp();
        logic [39:0] c; longint at; int a, t, q; bit seen = 0;
        wr(5'd13, 8'd5); wr(5'd14, 8'd0); wr(5'd23, 8'h01);
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (rx_start) seen = 1;
        end
        check("R6 rx strobe seen", seen, 1);
        check("R8 tx quiet", tx_start | irq_out, 0);
        sof_evt = 1'b1; at = cyc;
        @(posedge clk); #1 sof_evt = 1'b0;
        @(negedge clk);
        check("R6 single cycle", rx_start, 0);
        rd_cap(c);
        check("R6 match value", c[15:0], 16'd5);
        count(100, a, t, q);
        check("R6 rx per 100", a, 10);
        check("R8 others off", t + q, 0);
    endtask

    task automatic t_routes();
        int a, t, q;
        wr(5'd15, 8'd9); wr(5'd16, 8'd0);
        wr(5'd13, 8'd2); wr(5'd23, 8'h0B);
        count(100, a, t, q);
        check("R8 tx count", t, 10);
        check("R8 irq count", q, 10);
        check("R8 rx count", a, 0);
        wr(5'd15, 8'd2); wr(5'd23, 8'h0F);
        count(100, a, t, q);
        check("R8 or merge irq", q, 10);
    endtask

    task automatic t_percmp();
        logic [39:0] c; longint at; logic [23:0] v; bit seen = 0;
        wr(5'd23, 8'h00); wr(5'd0, 8'd3);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b0, at); rd_cap(c);
        v = c[39:16] + 24'd20;
        wr(5'd17, v[7:0]); wr(5'd18, v[15:8]); wr(5'd19, v[23:16]);
        wr(5'd23, 8'h30);
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk);
            if (irq_out) seen = 1;
        end
        check("R7 irq seen", seen, 1);
        sof_evt = 1'b1;
        @(posedge clk); #1 sof_evt = 1'b0;
        @(negedge clk);
        check("R7 single cycle", irq_out, 0);
        rd_cap(c);
        check("R7 period match", c[39:16], v);
        check("R7 sub zero", c[15:0], 0);
        wr(5'd23, 8'h00);
    endtask

    task automatic t_atomic();
        logic [39:0] c, s; logic [7:0] b;
        @(negedge clk); reg_re = 1'b1; reg_addr = 5'd2; sof_evt = 1'b1;
        #1 s[7:0] = reg_rdata;
        @(posedge clk); #1 reg_re = 1'b0; sof_evt = 1'b0;
        repeat (25) @(negedge clk);
        for (int k = 1; k < 5; k++) begin
            rd(5'(2 + k), b);
            s[8*k +: 8] = b;
        end
        rd_cap(c);
        check("R5 shadow time", s, c);
    endtask

    task automatic t_events();
        logic [7:0] b; longint at;
        pulse(1'b0, 1'b1, at);
        rd(5'd12, b); check("R9 eot source", b, 8'h05);
        rd(5'd7, b);
        rd(5'd12, b); check("R9 ack clears", b, 8'h04);
        pulse(1'b1, 1'b1, at);
        rd(5'd12, b); check("R9 sof priority", b, 8'h01);
        rd(5'd7, b);
        pulse(1'b0, 1'b1, at);
        pulse(1'b1, 1'b0, at);
        rd(5'd12, b); check("R10 overrun set", b, 8'h03);
        wr(5'd12, 8'h02);
        rd(5'd12, b); check("R10 overrun clear", b, 8'h01);
        rd(5'd7, b);
        rd(5'd12, b); check("R9 pending clear", b, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_subcmp();
        t_routes();
        t_percmp();
        t_atomic();
        t_events();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule